// File: doc/BRIEF.md
# Delayed-Trigger Capture Controller

This block steers writes into a circular sample memory so that one acquisition holds a full window around a delayed trigger point. It is started by an arm pulse. From then on it writes one sample per clock at a wrapping address. It first fills a pre-trigger region whose size follows from a placement setting: start, middle, end, or a percentage of the buffer. Once that region is full, it accepts the trigger. It then waits a programmable number of cycles, and the sample written at that moment becomes the delayed trigger point. After that it writes the remaining post-trigger samples, stops, and presents the address of the point and the address of the oldest sample in the window.

A finished trace is kept until a restart pulse arrives. A restart with the hold input low begins a new acquisition at once. A restart with hold high is refused, so the result stays frozen for inspection.

The controller has six states:
- IDLE moves to FILL on arm, or to WAIT when the pre-trigger size is zero.
- FILL moves to WAIT when its last pre-trigger sample is written.
- WAIT moves on trigger: to DELAY when the delay is nonzero, to POST when more than one post sample remains, otherwise straight to DONE.
- DELAY moves to POST, or to DONE, when the delay expires.
- POST moves to DONE after its last sample.
- DONE moves to FILL or WAIT on an unheld restart.

Top module: `dtc_capture_ctrl`

## Requirements
- R1: After reset the block is idle, with write enable low, done low, and write address, trigger address and oldest address all zero.
- R2: An arm pulse in IDLE starts writing in the next cycle at address 0, with one write per cycle and the address stepping by one and wrapping modulo DEPTH. Trigger and restart pulses in IDLE have no effect.
- R3: The pre-trigger size is taken from the 2-bit placement code: 0 gives 0, 1 gives DEPTH/2, 2 gives DEPTH-1, and 3 gives floor(DEPTH*pct/100). With code 3, a pct of 100 or more gives DEPTH-1.
- R4: A trigger is ignored until the pre-trigger number of samples has been written since the start.
- R5: The delayed trigger point is the sample written `delay` cycles after the sample written in the trigger cycle. A delay of 0 makes it the trigger sample itself.
- R6: Writing stops after DEPTH minus pre samples have been written, counting from the delayed point inclusive. Done is high from the following cycle and write enable is low.
- R7: While done is high, the trigger address output holds the delayed point's address, and the oldest address output holds that address minus pre, modulo DEPTH. Both stay stable.
- R8: A restart pulse in DONE with hold low starts a new acquisition at address 0, using the settings present at that moment. With hold high the block stays in DONE with its outputs unchanged.
- R9: Placement, percentage and delay are sampled only when an acquisition starts. Later changes to them do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm_i | input | 1 | Start pulse, honoured in IDLE |
| trig_i | input | 1 | Trigger event, honoured in WAIT |
| restart_i | input | 1 | New-acquisition request, honoured in DONE |
| hold_i | input | 1 | Refuses restart while high |
| place_i | input | 2 | Placement code of the delayed point |
| pct_i | input | 7 | Pre-trigger percentage for placement code 3 |
| delay_i | input | DLY_W | Trigger delay in cycles |
| wr_en_o | output | 1 | Sample write strobe |
| wr_addr_o | output | AW | Sample write address |
| done_o | output | 1 | Acquisition finished |
| trig_addr_o | output | AW | Address of the delayed trigger point |
| oldest_addr_o | output | AW | Address of the oldest sample in the window |

## Verification
The bench builds the block with AW=4 (a 16-entry buffer) and DLY_W=6. The small buffer makes address wrap, every placement code, the one-sample post region of end placement and percentage rounding all reachable within a few dozen cycles. The 6-bit delay allows delays longer than two buffer lengths, so the pointer wraps several times between trigger and point.

// File: rtl/dtc_pkg.sv
package dtc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL,
        ST_WAIT,
        ST_DELAY,
        ST_POST,
        ST_DONE
    } cap_state_t;

    localparam logic [1:0] PLACE_START = 2'd0;
    localparam logic [1:0] PLACE_MID   = 2'd1;
    localparam logic [1:0] PLACE_END   = 2'd2;
    localparam logic [1:0] PLACE_PCT   = 2'd3;

    localparam int PCT_W = 7;

endpackage

// File: rtl/dtc_place.sv
module dtc_place
    import dtc_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic [1:0]       place_i,
    input  logic [PCT_W-1:0] pct_i,
    output logic [AW:0]      pre_o,
    output logic [AW:0]      post_o
);

    localparam int DEPTH = 1 << AW;
    localparam int PW    = AW + PCT_W;

    logic [PW-1:0] scaled;
    logic [PW-1:0] quot;

    // pct * DEPTH is a shift; the constant divide gives the floor
    assign scaled = {pct_i, {AW{1'b0}}};
    assign quot   = scaled / PW'(100);

    always_comb begin
        unique case (place_i)
            PLACE_START: pre_o = '0;
            PLACE_MID:   pre_o = (AW+1)'(DEPTH / 2);
            PLACE_END:   pre_o = (AW+1)'(DEPTH - 1);
            PLACE_PCT: begin
                if (pct_i >= PCT_W'(100)) pre_o = (AW+1)'(DEPTH - 1);
                else                      pre_o = quot[AW:0];
            end
        endcase
    end

    assign post_o = (AW+1)'(DEPTH) - pre_o;

    // R3: pre-trigger region never covers the whole buffer
    always_comb begin
        p_pre_range_r3: assert (pre_o < (AW+1)'(DEPTH))
            else $error("pre-trigger size out of range");
    end

endmodule

// File: rtl/dtc_count.sv
module dtc_count #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         dec_i,
    output logic [W-1:0] cnt_o
);

    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_o <= '0;
        else if (load_i) cnt_o <= load_val_i;
        else if (dec_i)  cnt_o <= cnt_o - 1'b1;
    end

    // R6: the controller never counts a window below zero
    p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_i && !load_i) |-> (cnt_o != '0));

endmodule

// File: rtl/dtc_capture_ctrl.sv
module dtc_capture_ctrl
    import dtc_pkg::*;
#(
    parameter int AW    = 12,
    parameter int DLY_W = 25
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm_i,
    input  logic             trig_i,
    input  logic             restart_i,
    input  logic             hold_i,
    input  logic [1:0]       place_i,
    input  logic [6:0]       pct_i,
    input  logic [DLY_W-1:0] delay_i,
    output logic             wr_en_o,
    output logic [AW-1:0]    wr_addr_o,
    output logic             done_o,
    output logic [AW-1:0]    trig_addr_o,
    output logic [AW-1:0]    oldest_addr_o
);

    localparam int CW = AW + 1;

    cap_state_t st, st_nx;

    logic [CW-1:0]    pre_calc, post_calc;
    logic [CW-1:0]    pre_q, post_q;
    logic [DLY_W-1:0] delay_q;
    logic [AW-1:0]    wr_ptr, trig_addr_q;
    logic [CW-1:0]    fill_cnt, post_cnt;
    logic [DLY_W-1:0] dly_cnt;

    logic start, writing, trig_hit, point_now, last_post;

    dtc_place #(.AW(AW)) place_i0 (
        .place_i (place_i),
        .pct_i   (pct_i),
        .pre_o   (pre_calc),
        .post_o  (post_calc)
    );

    assign start = ((st == ST_IDLE) && arm_i) ||
                   ((st == ST_DONE) && restart_i && !hold_i);
    assign writing  = (st == ST_FILL) || (st == ST_WAIT) ||
                      (st == ST_DELAY) || (st == ST_POST);
    assign trig_hit = (st == ST_WAIT) && trig_i;
    assign point_now = (trig_hit && (delay_q == '0)) ||
                       ((st == ST_DELAY) && (dly_cnt == DLY_W'(1)));
    assign last_post = (post_q == CW'(1));

    dtc_count #(.W(CW)) fill_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (start),
        .load_val_i (pre_calc),
        .dec_i      (st == ST_FILL),
        .cnt_o      (fill_cnt)
    );

    dtc_count #(.W(DLY_W)) dly_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (trig_hit),
        .load_val_i (delay_q),
        .dec_i      (st == ST_DELAY),
        .cnt_o      (dly_cnt)
    );

    dtc_count #(.W(CW)) post_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (point_now),
        .load_val_i (post_q - 1'b1),
        .dec_i      (st == ST_POST),
        .cnt_o      (post_cnt)
    );

    // next-state logic
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: begin
                if (arm_i) st_nx = (pre_calc == '0) ? ST_WAIT : ST_FILL;
            end
            ST_FILL: begin
                if (fill_cnt == CW'(1)) st_nx = ST_WAIT;
            end
            ST_WAIT: begin
                if (trig_i) begin
                    if (delay_q != '0)  st_nx = ST_DELAY;
                    else if (last_post) st_nx = ST_DONE;
                    else                st_nx = ST_POST;
                end
            end
            ST_DELAY: begin
                if (point_now) st_nx = last_post ? ST_DONE : ST_POST;
            end
            ST_POST: begin
                if (post_cnt == CW'(1)) st_nx = ST_DONE;
            end
            ST_DONE: begin
                if (restart_i && !hold_i)
                    st_nx = (pre_calc == '0) ? ST_WAIT : ST_FILL;
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // settings, pointer and trigger address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr      <= '0;
            pre_q       <= '0;
            post_q      <= '0;
            delay_q     <= '0;
            trig_addr_q <= '0;
        end else begin
            if (start) begin
                wr_ptr  <= '0;
                pre_q   <= pre_calc;
                post_q  <= post_calc;
                delay_q <= delay_i;
            end else if (writing) begin
                wr_ptr <= wr_ptr + 1'b1;
            end
            if (point_now) trig_addr_q <= wr_ptr;
        end
    end

    // outputs
    always_comb begin
        wr_en_o       = writing;
        wr_addr_o     = wr_ptr;
        done_o        = (st == ST_DONE);
        trig_addr_o   = trig_addr_q;
        oldest_addr_o = trig_addr_q - pre_q[AW-1:0];
    end

    // R2: consecutive writes step the address by one
    p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && $past(wr_en_o)) |-> (wr_addr_o == $past(wr_addr_o) + 1'b1));

    // R2: without arm the block stays idle
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_IDLE) && !arm_i) |=> (st == ST_IDLE));

    // R4: no trigger is taken while the pre-trigger region fills
    p_fill_no_trig_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FILL) |=> ((st == ST_FILL) || (st == ST_WAIT)));

    // R6: completion directly follows a write
    p_done_after_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(wr_en_o));

    // R7: result addresses frozen while done
    p_done_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && $past(done_o)) |-> ($stable(trig_addr_o) && $stable(oldest_addr_o)));

    // R8: hold keeps the completed trace
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && hold_i) |=> done_o);

endmodule

// File: tb/dtc_capture_ctrl_tb_top.sv
module dtc_capture_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW    = 4;
    localparam int DLY_W = 6;
    localparam int DEPTH = 1 << AW;
    localparam int NVEC  = 8;

    // vector table: placement, percent, delay, trigger write index
    localparam int V_PLACE[NVEC] = '{0, 1, 2, 1, 3, 3, 0, 2};
    localparam int V_PCT  [NVEC] = '{0, 0, 0, 0, 25, 100, 0, 0};
    localparam int V_DLY  [NVEC] = '{0, 0, 0, 5, 3, 1, 40, 0};
    localparam int V_K    [NVEC] = '{0, 8, 20, 10, 4, 15, 3, 15};

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             arm_i = 1'b0;
    logic             trig_i = 1'b0;
    logic             restart_i = 1'b0;
    logic             hold_i = 1'b0;
    logic [1:0]       place_i = '0;
    logic [6:0]       pct_i = '0;
    logic [DLY_W-1:0] delay_i = '0;
    logic             wr_en_o, done_o;
    logic [AW-1:0]    wr_addr_o, trig_addr_o, oldest_addr_o;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    dtc_capture_ctrl #(.AW(AW), .DLY_W(DLY_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .trig_i(trig_i),
        .restart_i(restart_i), .hold_i(hold_i), .place_i(place_i),
        .pct_i(pct_i), .delay_i(delay_i), .wr_en_o(wr_en_o),
        .wr_addr_o(wr_addr_o), .done_o(done_o), .trig_addr_o(trig_addr_o),
        .oldest_addr_o(oldest_addr_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_tests = n_tests + 1;
            n_fail  = n_fail + 1;
            $display("FAIL watchdog: act=%0d exp=<150000 cycles", cycles);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests = n_tests + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_pre(input int p, input int pct);
        case (p)
            0:       return 0;
            1:       return DEPTH / 2;
            2:       return DEPTH - 1;
            default: return (pct >= 100) ? DEPTH - 1 : (DEPTH * pct) / 100;
        endcase
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; arm_i = 0; trig_i = 0; restart_i = 0; hold_i = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // one acquisition; kign < 0 means no early trigger
    task automatic capture(input int p, input int pct, input int d,
                           input int kign, input int k, input bit via_restart);
        int n = 0;
        int bad_addr = 0;
        int guard = 0;
        int pre = exp_pre(p, pct);
        int post = DEPTH - pre;
        int point = k + d;
        @(negedge clk);
        place_i = 2'(p); pct_i = 7'(pct); delay_i = DLY_W'(d);
        if (via_restart) restart_i = 1'b1; else arm_i = 1'b1;
        @(negedge clk);
        arm_i = 1'b0; restart_i = 1'b0;
        // R9: scramble settings after the start
        place_i = ~2'(p); pct_i = 7'h55; delay_i = ~DLY_W'(d);
        while (!done_o && guard < 2000) begin
            if (wr_en_o) begin
                if (int'(wr_addr_o) != (n % DEPTH)) bad_addr = bad_addr + 1;
                trig_i = (n == k) || (n == kign);
                n = n + 1;
            end else begin
                trig_i = 1'b0;
            end
            guard = guard + 1;
            @(negedge clk);
        end
        trig_i = 1'b0;
        chk(done_o == 1'b1, "R6 done reached", int'(done_o), 1);
        chk(bad_addr == 0, "R2 address sequence", bad_addr, 0);
        chk(n == point + post, "R4 R6 write count", n, point + post);
        chk(int'(trig_addr_o) == (point % DEPTH), "R5 R9 trigger address",
            int'(trig_addr_o), point % DEPTH);
        chk(int'(oldest_addr_o) == ((point - pre) % DEPTH), "R3 R7 oldest address",
            int'(oldest_addr_o), (point - pre) % DEPTH);
        chk(wr_en_o == 1'b0, "R6 writes stopped", int'(wr_en_o), 0);
    endtask

    initial begin
        do_reset();
        @(negedge clk);
        // R1 reset state
        chk(wr_en_o == 1'b0, "R1 wr_en after reset", int'(wr_en_o), 0);
        chk(done_o == 1'b0, "R1 done after reset", int'(done_o), 0);
        chk(wr_addr_o == '0, "R1 addr after reset", int'(wr_addr_o), 0);
        chk(trig_addr_o == '0 && oldest_addr_o == '0, "R1 result after reset",
            int'(trig_addr_o), 0);

        // R2: trigger and restart in IDLE do nothing
        trig_i = 1'b1; restart_i = 1'b1;
        repeat (3) @(negedge clk);
        trig_i = 1'b0; restart_i = 1'b0;
        @(negedge clk);
        chk(wr_en_o == 1'b0 && done_o == 1'b0, "R2 idle ignores pulses",
            int'(wr_en_o) + int'(done_o), 0);

        // vector table
        for (int i = 0; i < NVEC; i++) begin
            do_reset();
            capture(V_PLACE[i], V_PCT[i], V_DLY[i], -1, V_K[i], 1'b0);
        end

        // R4: early trigger during fill ignored (middle placement)
        do_reset();
        capture(1, 0, 0, 3, 12, 1'b0);

        // R8: restart while hold is high is refused
        begin
            logic [AW-1:0] ta;
            logic [AW-1:0] oa;
            ta = trig_addr_o; oa = oldest_addr_o;
            hold_i = 1'b1; restart_i = 1'b1;
            repeat (3) @(negedge clk);
            restart_i = 1'b0;
            @(negedge clk);
            chk(done_o == 1'b1 && wr_en_o == 1'b0, "R8 hold keeps done",
                int'(done_o), 1);
            chk(trig_addr_o == ta && oldest_addr_o == oa, "R8 hold keeps result",
                int'(trig_addr_o), int'(ta));
            hold_i = 1'b0;
        end

        // R8: restart with new settings, percent placement
        capture(3, 10, 2, -1, 5, 1'b1);
        // R8: second restart, end placement with wrap
        capture(2, 0, 7, 4, 30, 1'b1);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule